// File: doc/BRIEF.md
# Floating-Point Register Load Unit (Immediate Offset)

This unit takes one 32-bit load instruction word aimed at the floating-point register file and carries it out to completion. Two encoding forms can be fed to it. In the first, bits 31:28 hold a condition code. In the second, the upper bits are a fixed prefix. A side input states which form is presented. The unit decodes the element size and flags encodings that are undefined or unpredictable. It then computes a byte address from a base value and an unsigned immediate that is scaled and signed. Next it reads memory one 32-bit word at a time over a pulse request / response port. Last, it writes the destination register through a single write port that is 32 or 64 bits wide.

The condition evaluation is done outside the unit and arrives as a single pass bit. The base register value also comes from outside, on `base_i`, for the register named in bits 19:16. A 64-bit load is split into two ordered word reads. The two words are joined according to the endianness input latched when the instruction is accepted.

Field positions in the word are bit 23 for the offset sign, bit 22 for the extra index bit, bits 19:16 for the base register number, bits 15:12 for the index field, bits 9:8 for the size and bits 7:0 for the immediate.

Top module: `fp_imm_load_unit`

## Requirements
- R1: Size code 00 is undefined, and size code 01 is undefined when `half_en_i` is low. An undefined instruction raises `undef_o`, issues no memory request and performs no register write.
- R2: When `cond_pass_i` is low at acceptance, the instruction is consumed with no memory request and no register write.
- R3: The offset is imm8 shifted left by 1 for size 01 and by 2 for sizes 10 and 11, zero-extended. Bit 23 set adds the offset to the base and bit 23 clear subtracts it. The result is the first request address.
- R4: When bits 19:16 equal 15, the base is `pc_i` with bits 1:0 cleared instead of `base_i`.
- R5: The destination index is {bits 15:12, bit 22} for sizes 01 and 10, and {bit 22, bits 15:12} for size 11.
- R6: A size 01 load issues one request with byte enable 0011 when address bit 1 is 0 and 1100 when it is 1. It writes the selected 16-bit lane zero-extended, with `rf_wide_o` low.
- R7: A size 10 load issues one request with byte enable 1111 and writes the returned word, with `rf_wide_o` low and upper data bits zero.
- R8: A size 11 load reads first the address and then the address plus 4, each with enable 1111. The second request is issued only after the first response. With `big_end_i` high the written value is {first, second}, and with it low the value is {second, first}. `rf_wide_o` is high.
- R9: `unpred_o` is raised for a defined size 01 instruction when, in the condition form, bits 31:28 differ from 1110, or, in the prefix form, `in_blk_i` is high. Such an instruction still executes when its condition passes.
- R10: `instr_ready_o` is high only while idle. `busy_o` stays high from acceptance until the cycle of the single register write and falls right after it.
- R11: After reset the unit is idle and ready, with no request, no write and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word offered |
| instr_ready_o | output | 1 | Unit can accept an instruction |
| instr_i | input | 32 | Instruction word |
| form_i | input | 1 | 0: condition form, 1: fixed-prefix form |
| cond_pass_i | input | 1 | External condition check passed |
| in_blk_i | input | 1 | Instruction sits in a conditional block (prefix form) |
| half_en_i | input | 1 | 16-bit element support present |
| big_end_i | input | 1 | Big-endian data order for 64-bit merge |
| pc_i | input | AW | Program counter value |
| base_i | input | AW | Value of base register named in bits 19:16 |
| busy_o | output | 1 | Instruction in progress |
| undef_o | output | 1 | Last accepted instruction undefined |
| unpred_o | output | 1 | Last accepted instruction unpredictable |
| mem_req_o | output | 1 | One-cycle word read request |
| mem_addr_o | output | AW | Request byte address |
| mem_be_o | output | 4 | Request byte enables |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response word |
| rf_we_o | output | 1 | Register write strobe |
| rf_wide_o | output | 1 | Write is 64 bits |
| rf_idx_o | output | 5 | Destination register index |
| rf_wdata_o | output | 64 | Write data |

## Verification
The assertions assume the memory side returns exactly one `mem_rvalid_i` pulse per request and never one before its request. They also assume that `instr_i` and the side inputs stay steady in the cycle they are accepted. The bench memory model sees each request pulse at the falling edge and answers it once after a random delay of one to three cycles. It drives a new instruction only after `busy_o` has fallen, so responses never overlap and no instruction arrives mid-load.

// File: rtl/fpld_pkg.sv
package fpld_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned BE_W   = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BAD = 2'b00,
    SZ_H   = 2'b01,
    SZ_W   = 2'b10,
    SZ_DW  = 2'b11
  } esz_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ1,
    S_WAIT1,
    S_REQ2,
    S_WAIT2,
    S_WR
  } st_e;
endpackage

// File: rtl/fpld_decode.sv
module fpld_decode
  import fpld_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [31:0]      instr_i,
  input  logic             form_i,
  input  logic             cond_pass_i,
  input  logic             in_blk_i,
  input  logic             half_en_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    base_i,
  output logic             undef_o,
  output logic             unpred_o,
  output logic             go_o,
  output esz_e             esz_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [AW-1:0]    addr_o
);
  localparam logic [3:0] RN_PC   = 4'hf;
  localparam logic [3:0] CC_ALWS = 4'he;

  logic [AW-1:0] off, base;
  logic          unused_dec;

  assign unused_dec = ^{instr_i[27:24], instr_i[21:20], instr_i[11:10], pc_i[1:0]};

  always_comb begin
    esz_o    = esz_e'(instr_i[9:8]);
    undef_o  = (esz_o == SZ_BAD) || (esz_o == SZ_H && !half_en_i);
    unpred_o = !undef_o && esz_o == SZ_H &&
               (form_i ? in_blk_i : (instr_i[31:28] != CC_ALWS));
    go_o     = !undef_o && cond_pass_i;
    off      = (esz_o == SZ_H) ? AW'({instr_i[7:0], 1'b0}) : AW'({instr_i[7:0], 2'b00});
    base     = (instr_i[19:16] == RN_PC) ? {pc_i[AW-1:2], 2'b00} : base_i;
    addr_o   = instr_i[23] ? (base + off) : (base - off);
    idx_o    = (esz_o == SZ_DW) ? {instr_i[22], instr_i[15:12]} : {instr_i[15:12], instr_i[22]};
  end
endmodule

// File: rtl/fpld_merge.sv
module fpld_merge
  import fpld_pkg::*;
(
  input  esz_e              esz_i,
  input  logic              lane_hi_i,
  input  logic              big_i,
  input  logic [WORD_W-1:0] w1_i,
  input  logic [WORD_W-1:0] w2_i,
  output logic [2*WORD_W-1:0] data_o
);
  localparam int unsigned HW = WORD_W / 2;

  always_comb begin
    unique case (esz_i)
      SZ_H:    data_o = {{(2*WORD_W-HW){1'b0}}, (lane_hi_i ? w1_i[WORD_W-1:HW] : w1_i[HW-1:0])};
      SZ_DW:   data_o = big_i ? {w1_i, w2_i} : {w2_i, w1_i};
      default: data_o = {{WORD_W{1'b0}}, w1_i};
    endcase
  end
endmodule

// File: rtl/fpld_seq.sv
module fpld_seq
  import fpld_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  output logic              idle_o,
  input  logic              d_undef_i,
  input  logic              d_unpred_i,
  input  logic              d_go_i,
  input  esz_e              d_esz_i,
  input  logic [IDX_W-1:0]  d_idx_i,
  input  logic [AW-1:0]     d_addr_i,
  input  logic              big_i,
  output logic              undef_o,
  output logic              unpred_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              rf_we_o,
  output logic              rf_wide_o,
  output logic [IDX_W-1:0]  rf_idx_o,
  output logic [2*WORD_W-1:0] rf_wdata_o
);
  localparam logic [AW-1:0] STEP = AW'(BE_W);

  st_e               st_q;
  esz_e              esz_q;
  logic [AW-1:0]     addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] w1_q, w2_q;
  logic              big_q;
  logic              acc;

  assign idle_o = (st_q == S_IDLE);
  assign acc    = acc_valid_i && idle_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      esz_q    <= SZ_W;
      addr_q   <= '0;
      idx_q    <= '0;
      w1_q     <= '0;
      w2_q     <= '0;
      big_q    <= 1'b0;
      undef_o  <= 1'b0;
      unpred_o <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (acc) begin
          undef_o  <= d_undef_i;
          unpred_o <= d_unpred_i;
          if (d_go_i) begin
            esz_q  <= d_esz_i;
            addr_q <= d_addr_i;
            idx_q  <= d_idx_i;
            big_q  <= big_i;
            st_q   <= S_REQ1;
          end
        end
        S_REQ1:  st_q <= S_WAIT1;
        S_WAIT1: if (mem_rvalid_i) begin
          w1_q <= mem_rdata_i;
          st_q <= (esz_q == SZ_DW) ? S_REQ2 : S_WR;
        end
        S_REQ2:  st_q <= S_WAIT2;
        S_WAIT2: if (mem_rvalid_i) begin
          w2_q <= mem_rdata_i;
          st_q <= S_WR;
        end
        S_WR:    st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == S_REQ1) || (st_q == S_REQ2);
  assign mem_addr_o = (st_q == S_REQ2) ? (addr_q + STEP) : addr_q;

  always_comb begin
    if (esz_q == SZ_H) mem_be_o = addr_q[1] ? 4'b1100 : 4'b0011;
    else               mem_be_o = '1;
  end

  assign rf_we_o   = (st_q == S_WR);
  assign rf_wide_o = (esz_q == SZ_DW);
  assign rf_idx_o  = idx_q;

  fpld_merge u_merge (
    .esz_i    (esz_q),
    .lane_hi_i(addr_q[1]),
    .big_i    (big_q),
    .w1_i     (w1_q),
    .w2_i     (w2_q),
    .data_o   (rf_wdata_o)
  );
endmodule

// File: rtl/fp_imm_load_unit.sv
module fp_imm_load_unit
  import fpld_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                instr_valid_i,
  output logic                instr_ready_o,
  input  logic [31:0]         instr_i,
  input  logic                form_i,
  input  logic                cond_pass_i,
  input  logic                in_blk_i,
  input  logic                half_en_i,
  input  logic                big_end_i,
  input  logic [AW-1:0]       pc_i,
  input  logic [AW-1:0]       base_i,
  output logic                busy_o,
  output logic                undef_o,
  output logic                unpred_o,
  output logic                mem_req_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [BE_W-1:0]     mem_be_o,
  input  logic                mem_rvalid_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic                rf_we_o,
  output logic                rf_wide_o,
  output logic [IDX_W-1:0]    rf_idx_o,
  output logic [2*WORD_W-1:0] rf_wdata_o
);
  logic             d_undef, d_unpred, d_go, idle;
  esz_e             d_esz;
  logic [IDX_W-1:0] d_idx;
  logic [AW-1:0]    d_addr;

  fpld_decode #(.AW(AW)) u_dec (
    .instr_i    (instr_i),
    .form_i     (form_i),
    .cond_pass_i(cond_pass_i),
    .in_blk_i   (in_blk_i),
    .half_en_i  (half_en_i),
    .pc_i       (pc_i),
    .base_i     (base_i),
    .undef_o    (d_undef),
    .unpred_o   (d_unpred),
    .go_o       (d_go),
    .esz_o      (d_esz),
    .idx_o      (d_idx),
    .addr_o     (d_addr)
  );

  fpld_seq #(.AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (instr_valid_i),
    .idle_o      (idle),
    .d_undef_i   (d_undef),
    .d_unpred_i  (d_unpred),
    .d_go_i      (d_go),
    .d_esz_i     (d_esz),
    .d_idx_i     (d_idx),
    .d_addr_i    (d_addr),
    .big_i       (big_end_i),
    .undef_o     (undef_o),
    .unpred_o    (unpred_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .rf_we_o     (rf_we_o),
    .rf_wide_o   (rf_wide_o),
    .rf_idx_o    (rf_idx_o),
    .rf_wdata_o  (rf_wdata_o)
  );

  assign instr_ready_o = idle;
  assign busy_o        = !idle;
endmodule

// File: rtl/fpld_chk.sv
module fpld_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          instr_valid_i,
  input logic          instr_ready_o,
  input logic [1:0]    size_i,
  input logic          busy_o,
  input logic          undef_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [3:0]    mem_be_o,
  input logic          mem_rvalid_i,
  input logic          rf_we_o
);
  logic          pend_q, second_q;
  logic [AW-1:0] a1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      second_q <= 1'b0;
      a1_q     <= '0;
    end else begin
      if (mem_req_o)         pend_q <= 1'b1;
      else if (mem_rvalid_i) pend_q <= 1'b0;
      if (instr_valid_i && instr_ready_o) second_q <= 1'b0;
      else if (mem_req_o && !second_q) begin
        second_q <= 1'b1;
        a1_q     <= mem_addr_o;
      end
    end
  end

  // R8
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !pend_q);
  // R8
  second_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && second_q |-> mem_addr_o == a1_q + AW'(4));
  // R6
  half_lane_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_be_o == 4'b0011 |-> !mem_addr_o[1]);
  // R6
  half_lane_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_be_o == 4'b1100 |-> mem_addr_o[1]);
  // R7
  be_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_be_o == 4'b1111 || mem_be_o == 4'b0011 || mem_be_o == 4'b1100));
  // R10
  final_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !busy_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rf_we_o && !mem_req_o);
  // R1
  undef_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_ready_o && size_i == 2'b00 |=> undef_o && !busy_o);
endmodule

bind fp_imm_load_unit fpld_chk #(.AW(AW)) u_fpld_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_valid_i(instr_valid_i),
  .instr_ready_o(instr_ready_o),
  .size_i       (instr_i[9:8]),
  .busy_o       (busy_o),
  .undef_o      (undef_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_be_o     (mem_be_o),
  .mem_rvalid_i (mem_rvalid_i),
  .rf_we_o      (rf_we_o)
);

// File: tb/fp_imm_load_unit_tb_top.sv
`timescale 1ns/1ps
module fp_imm_load_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [31:0] instr = '0;
  logic        form = 1'b0, cpass = 1'b0, blk = 1'b0, hen = 1'b0, bend = 1'b0;
  logic [31:0] pc = '0, base = '0;
  logic        busy, undef, unpred, mreq, rvalid = 1'b0, we, wide;
  logic [31:0] maddr, rdata = '0;
  logic [3:0]  mbe;
  logic [4:0]  widx;
  logic [63:0] wdata;

  int checks = 0, fails = 0;
  int req_cnt = 0, wr_cnt = 0;
  logic [31:0] req_addr [2];
  logic [3:0]  req_be [2];
  logic [4:0]  cap_idx;
  logic [63:0] cap_data;
  logic        cap_wide;
  logic        pend = 1'b0;
  int          lat = 0;
  logic [31:0] paddr = '0;

  always #2.5 clk = ~clk;

  fp_imm_load_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_ready_o(ready),
    .instr_i(instr), .form_i(form), .cond_pass_i(cpass), .in_blk_i(blk),
    .half_en_i(hen), .big_end_i(bend), .pc_i(pc), .base_i(base),
    .busy_o(busy), .undef_o(undef), .unpred_o(unpred),
    .mem_req_o(mreq), .mem_addr_o(maddr), .mem_be_o(mbe),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .rf_we_o(we), .rf_wide_o(wide), .rf_idx_o(widx), .rf_wdata_o(wdata)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return ((a >> 2) * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder and port monitor
  initial forever begin
    @(negedge clk);
    rvalid = 1'b0;
    if (pend) begin
      if (lat == 0) begin
        rvalid = 1'b1;
        rdata  = mem_word(paddr);
        pend   = 1'b0;
      end else lat--;
    end
    if (mreq) begin
      if (req_cnt < 2) begin
        req_addr[req_cnt] = maddr;
        req_be[req_cnt]   = mbe;
      end
      req_cnt++;
      pend  = 1'b1;
      lat   = $urandom % 3;
      paddr = maddr;
    end
    if (we) begin
      wr_cnt++;
      cap_idx  = widx;
      cap_data = wdata;
      cap_wide = wide;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic run_one(input logic [31:0] ins, input bit f, input bit cp, input bit bl,
                         input bit he, input bit be, input logic [31:0] pcv,
                         input logic [31:0] bv);
    logic [1:0]  sz;
    bit          e_undef, e_unpred, go;
    logic [31:0] off, b, a, w1, w2;
    logic [3:0]  e_be;
    logic [4:0]  e_idx;
    logic [63:0] e_data;
    int          nreq, g;
    string       atag, dtag;
    sz       = ins[9:8];
    e_undef  = (sz == 2'b00) || (sz == 2'b01 && !he);
    e_unpred = !e_undef && sz == 2'b01 && (f ? bl : ins[31:28] != 4'he);
    go       = !e_undef && cp;
    off      = (sz == 2'b01) ? {23'd0, ins[7:0], 1'b0} : {22'd0, ins[7:0], 2'b00};
    b        = (ins[19:16] == 4'hf) ? (pcv & ~32'd3) : bv;
    a        = ins[23] ? b + off : b - off;
    atag     = (ins[19:16] == 4'hf) ? "R4" : "R3";
    nreq     = go ? ((sz == 2'b11) ? 2 : 1) : 0;
    e_be     = (sz == 2'b01) ? (a[1] ? 4'b1100 : 4'b0011) : 4'b1111;
    e_idx    = (sz == 2'b11) ? {ins[22], ins[15:12]} : {ins[15:12], ins[22]};
    w1       = mem_word(a);
    w2       = mem_word(a + 32'd4);
    case (sz)
      2'b01:   begin e_data = {48'd0, (a[1] ? w1[31:16] : w1[15:0])}; dtag = "R6"; end
      2'b11:   begin e_data = be ? {w1, w2} : {w2, w1}; dtag = "R8"; end
      default: begin e_data = {32'd0, w1}; dtag = "R7"; end
    endcase

    @(negedge clk); #1;
    chk(ready === 1'b1, "R10", "ready when idle", 64'(ready), 64'd1);
    req_cnt = 0; wr_cnt = 0;
    instr = ins; form = f; cpass = cp; blk = bl; hen = he; bend = be; pc = pcv; base = bv;
    valid = 1'b1;
    @(negedge clk); #1;
    valid = 1'b0;
    chk(undef === e_undef, "R1", "undef flag", 64'(undef), 64'(e_undef));
    chk(unpred === e_unpred, "R9", "unpred flag", 64'(unpred), 64'(e_unpred));
    chk(busy === go, "R10", "busy after accept", 64'(busy), 64'(go));
    g = 0;
    while (busy && g < 60) begin
      @(negedge clk); #1;
      g++;
    end
    chk(g < 60, "R10", "completion", 64'(g), 64'd0);
    chk(req_cnt == nreq, go ? dtag : (e_undef ? "R1" : "R2"), "request count",
        64'(req_cnt), 64'(nreq));
    chk(wr_cnt == (go ? 1 : 0), go ? "R10" : (e_undef ? "R1" : "R2"), "write count",
        64'(wr_cnt), 64'(go ? 1 : 0));
    if (go && req_cnt >= 1) begin
      chk(req_addr[0] == a, atag, "first address", 64'(req_addr[0]), 64'(a));
      chk(req_be[0] == e_be, dtag, "byte enable", 64'(req_be[0]), 64'(e_be));
    end
    if (go && sz == 2'b11 && req_cnt == 2)
      chk(req_addr[1] == a + 32'd4, "R8", "second address", 64'(req_addr[1]), 64'(a + 32'd4));
    if (go && wr_cnt == 1) begin
      chk(cap_idx == e_idx, "R5", "dest index", 64'(cap_idx), 64'(e_idx));
      chk(cap_data == e_data, dtag, "write data", cap_data, e_data);
      chk(cap_wide == (sz == 2'b11), dtag, "wide flag", 64'(cap_wide), 64'(sz == 2'b11));
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] cc, input bit u, input bit d,
                                     input logic [3:0] rn, input logic [3:0] vd,
                                     input logic [1:0] sz, input logic [7:0] imm);
    return {cc, 4'b1101, u, d, 2'b01, rn, vd, 2'b10, sz, imm};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk(busy === 1'b0, "R11", "busy in reset", 64'(busy), 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(ready === 1'b1 && mreq === 1'b0 && we === 1'b0, "R11", "idle after reset",
        {61'd0, ready, mreq, we}, 64'h4);
    chk(undef === 1'b0 && unpred === 1'b0, "R11", "flags after reset",
        64'({undef, unpred}), 64'd0);

    // directed corners
    run_one(mk(4'he, 1, 1, 4'h3, 4'ha, 2'b11, 8'h10), 0, 1, 0, 1, 1, 32'h0, 32'h0000_2000); // R8 big
    run_one(mk(4'he, 1, 0, 4'h3, 4'h5, 2'b11, 8'h10), 0, 1, 0, 1, 0, 32'h0, 32'h0000_2000); // R8 little
    run_one(mk(4'he, 0, 1, 4'h7, 4'h2, 2'b10, 8'hff), 0, 1, 0, 1, 0, 32'h0, 32'h0001_0000); // R3 max minus
    run_one(mk(4'he, 1, 0, 4'hf, 4'h1, 2'b10, 8'h04), 0, 1, 0, 1, 0, 32'h0000_8003, 32'hdead_beef); // R4
    run_one(mk(4'he, 1, 1, 4'h2, 4'h9, 2'b01, 8'h01), 0, 1, 0, 1, 0, 32'h0, 32'h0000_4000); // R6 hi lane
    run_one(mk(4'he, 1, 1, 4'h2, 4'h9, 2'b01, 8'hff), 0, 1, 0, 1, 0, 32'h0, 32'h0000_4000); // R6 max half
    run_one(mk(4'he, 1, 1, 4'h2, 4'h9, 2'b00, 8'h01), 0, 1, 0, 1, 0, 32'h0, 32'h0000_4000); // R1
    run_one(mk(4'he, 1, 1, 4'h2, 4'h9, 2'b01, 8'h01), 0, 1, 0, 0, 0, 32'h0, 32'h0000_4000); // R1 no half
    run_one(mk(4'he, 1, 1, 4'h2, 4'h9, 2'b10, 8'h01), 0, 0, 0, 1, 0, 32'h0, 32'h0000_4000); // R2
    run_one(mk(4'h0, 1, 1, 4'h2, 4'h9, 2'b01, 8'h02), 0, 1, 0, 1, 0, 32'h0, 32'h0000_4000); // R9 cond form
    run_one(mk(4'he, 1, 1, 4'h2, 4'h9, 2'b01, 8'h02), 1, 1, 1, 1, 0, 32'h0, 32'h0000_4000); // R9 prefix form
    run_one(mk(4'h0, 1, 1, 4'h2, 4'h9, 2'b10, 8'h02), 0, 1, 0, 1, 0, 32'h0, 32'h0000_4000); // R9 not half

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins;
      int r;
      bit f;
      ins = $urandom;
      r = $urandom % 16;
      ins[9:8] = (r == 0) ? 2'b00 : (r < 6) ? 2'b01 : (r < 11) ? 2'b10 : 2'b11;
      f = $urandom % 2;
      if (!f && ($urandom % 4) != 0) ins[31:28] = 4'he;
      if (($urandom % 8) == 0) ins[19:16] = 4'hf;
      run_one(ins, f, ($urandom % 8) != 0, ($urandom % 4) == 0, ($urandom % 6) != 0,
              $urandom % 2, $urandom, $urandom);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule